// File: doc/BRIEF.md
# Snooping Memory Controller with Posted Intervention Capture

This block is the memory-side agent on a snooping bus whose caches can pass modified lines directly to one another. After an address phase for a read, it looks the line up and returns it to the requester as two bus beats after a fixed access window. A cache that owns the line in modified state can answer the snoop with a hit-modified indication. The controller then gives up its own data return. It takes the two beats that the owning cache drives and holds them as a posted write-back line.

Posted lines sit in a small fully associative buffer. One line at a time drains to DRAM in any idle bus cycle in which DRAM reports it can accept a write. Because of this, a slow or busy DRAM never adds cycles to a bus transaction. A read that hits a buffered line is answered from the buffer, so stale DRAM contents are never returned. A second capture of a line that is already buffered replaces the older copy and does not take a new slot. When every slot is in use, the controller holds off new address phases until a drain frees one. The DRAM array is outside the block. It is reached through one read port and one write port that each carry a whole line.

Top module: `mem_ctrl`

## Requirements
- R1: Cycle 0 is the cycle in which `bus_addr_valid` is high while `bus_addr_hold` is low. For a read without hit-modified, `rd_beat_valid` is high in cycles ACCESS_CYC+1 and ACCESS_CYC+2 and low in cycles 1 to ACCESS_CYC. The first beat carries line bits [127:0] with `rd_beat_last` low. The second beat carries bits [255:128] with `rd_beat_last` high.
- R2: `snoop_hitm` is sampled at the end of cycle SNOOP_CYC. When it is high there, `rd_beat_valid` stays low for the whole transaction.
- R3: After a hit-modified, the two `own_beat_valid` beats from cycle ACCESS_CYC+1 on form a line (first beat = bits [127:0]). That line is later written to DRAM at the transaction's address.
- R4: A drain write (`dram_wr_en`) occurs only in a cycle with no transaction in progress and with `dram_wr_ready` high. Read timing does not depend on `dram_wr_ready`.
- R5: A read to an address that is held in the buffer returns the buffered line, and `dram_rd_en` stays low for that transaction.
- R6: A capture to an address already buffered overwrites that entry. It neither adds an entry nor causes an extra DRAM write.
- R7: With WB_DEPTH lines buffered, `bus_addr_hold` stays high until a drain frees a slot. It falls in the cycle after that drain.
- R8: After reset, `bus_addr_hold`, `rd_beat_valid`, `dram_rd_en` and `dram_wr_en` are low.
- R9: Only one transaction is in progress at a time. `bus_addr_hold` is high from cycle 1 until the transaction's last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr_valid | input | 1 | Read address phase offered |
| bus_addr | input | LINE_AW | Line address of the read |
| bus_addr_hold | output | 1 | Stalls address phases (busy or buffer full) |
| snoop_hitm | input | 1 | Combined hit-modified snoop response |
| own_beat_valid | input | 1 | Owning cache drives an intervention beat |
| own_beat_data | input | 128 | Intervention beat data |
| rd_beat_valid | output | 1 | Memory read beat valid |
| rd_beat_data | output | 128 | Memory read beat data |
| rd_beat_last | output | 1 | Marks the second beat |
| dram_rd_en | output | 1 | DRAM read in progress |
| dram_rd_addr | output | LINE_AW | DRAM read line address |
| dram_rd_line | input | 256 | DRAM read line |
| dram_wr_en | output | 1 | Drain write of one buffered line |
| dram_wr_addr | output | LINE_AW | Drain write address |
| dram_wr_line | output | 256 | Drain write line |
| dram_wr_ready | input | 1 | DRAM can accept a write this cycle |

## Verification
The bench builds the block with LINE_AW=8, WB_DEPTH=4, ACCESS_CYC=6 and SNOOP_CYC=2. The 8-bit line address lets the bench keep the whole DRAM as a plain array and compare every drained line. With four slots, the full-buffer stall is reached after only four distinct captures while `dram_wr_ready` is held low, even with a merge placed between them. The 6-cycle access window with a cycle-2 snoop yields the 10-clock read (arbitration and address cycles included), and it leaves clear room between the snoop sample and the first beat.

// File: rtl/mc_pkg.sv
package mc_pkg;
  localparam int BEAT_W = 128;
  localparam int LINE_W = 2 * BEAT_W;

  typedef enum logic [1:0] {
    SQ_IDLE    = 2'd0,
    SQ_ACCESS  = 2'd1,
    SQ_BEATS   = 2'd2,
    SQ_CAPTURE = 2'd3
  } seq_state_t;

  // beat 0 is the lower half of a line
  function automatic logic [BEAT_W-1:0] beat_of(input logic [LINE_W-1:0] line, input logic upper);
    return upper ? line[LINE_W-1:BEAT_W] : line[BEAT_W-1:0];
  endfunction

  function automatic logic [LINE_W-1:0] join_beats(input logic [BEAT_W-1:0] lo, input logic [BEAT_W-1:0] hi);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/mc_wbuf.sv
module mc_wbuf #(
  parameter int LINE_AW  = 16,
  parameter int WB_DEPTH = 4,
  parameter int LINE_W   = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINE_AW-1:0] look_addr,
  output logic               look_hit,
  output logic [LINE_W-1:0]  look_line,
  input  logic               cap_en,
  input  logic [LINE_AW-1:0] cap_addr,
  input  logic [LINE_W-1:0]  cap_line,
  output logic [WB_DEPTH-1:0] cap_match,
  output logic               cap_match_any,
  output logic               drain_pend,
  output logic [LINE_AW-1:0] drain_addr,
  output logic [LINE_W-1:0]  drain_line,
  input  logic               drain_take,
  output logic               full
);
  localparam int IW = (WB_DEPTH > 1) ? $clog2(WB_DEPTH) : 1;

  logic [WB_DEPTH-1:0] valid_q;
  logic [LINE_AW-1:0]  addr_q [WB_DEPTH];
  logic [LINE_W-1:0]   line_q [WB_DEPTH];
  logic [WB_DEPTH-1:0] look_match;
  logic [IW-1:0]       cap_slot;
  logic [IW-1:0]       drain_slot;

  function automatic logic [IW-1:0] lowest(input logic [WB_DEPTH-1:0] v);
    logic [IW-1:0] idx;
    idx = '0;
    for (int k = WB_DEPTH - 1; k >= 0; k--)
      if (v[k]) idx = IW'(k);
    return idx;
  endfunction

  for (genvar g = 0; g < WB_DEPTH; g++) begin : g_cmp
    assign look_match[g] = valid_q[g] && (addr_q[g] == look_addr);
    assign cap_match[g]  = valid_q[g] && (addr_q[g] == cap_addr);
  end

  assign look_hit      = |look_match;
  assign cap_match_any = |cap_match;
  assign full          = &valid_q;
  assign drain_pend    = |valid_q;
  assign cap_slot      = cap_match_any ? lowest(cap_match) : lowest(~valid_q);
  assign drain_slot    = lowest(valid_q);
  assign drain_addr    = addr_q[drain_slot];
  assign drain_line    = line_q[drain_slot];

  always_comb begin
    look_line = '0;
    for (int k = 0; k < WB_DEPTH; k++)
      if (look_match[k]) look_line = look_line | line_q[k];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      for (int k = 0; k < WB_DEPTH; k++) begin
        addr_q[k] <= '0;
        line_q[k] <= '0;
      end
    end else begin
      for (int k = 0; k < WB_DEPTH; k++) begin
        if (cap_en && cap_slot == IW'(k)) begin
          valid_q[k] <= 1'b1;
          addr_q[k]  <= cap_addr;
          line_q[k]  <= cap_line;
        end else if (drain_take && drain_slot == IW'(k)) begin
          valid_q[k] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mc_seq.sv
module mc_seq
  import mc_pkg::*;
#(
  parameter int LINE_AW    = 16,
  parameter int ACCESS_CYC = 6,
  parameter int SNOOP_CYC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [LINE_AW-1:0] req_addr,
  input  logic               buf_hit,
  input  logic [LINE_W-1:0]  buf_line,
  input  logic               snoop_hitm,
  input  logic               own_beat_valid,
  input  logic [BEAT_W-1:0]  own_beat_data,
  input  logic [LINE_W-1:0]  dram_rd_line,
  output logic               busy,
  output logic               dram_rd_en,
  output logic [LINE_AW-1:0] addr_q,
  output logic               rd_valid,
  output logic               rd_last,
  output logic [BEAT_W-1:0]  rd_data,
  output logic               cap_en,
  output logic [LINE_W-1:0]  cap_line,
  output logic               cancel_q
);
  localparam int CW = $clog2(ACCESS_CYC + 1);

  seq_state_t        state_q;
  logic [CW-1:0]     cnt_q;
  logic              hit_q;
  logic              beat1_q;
  logic [LINE_W-1:0] line_q;
  logic [BEAT_W-1:0] lo_q;
  logic              snoop_now;
  logic              access_end;

  assign snoop_now  = (cnt_q == CW'(SNOOP_CYC - 1)) && snoop_hitm;
  assign access_end = (cnt_q == CW'(ACCESS_CYC - 1));
  assign busy       = (state_q != SQ_IDLE);
  assign dram_rd_en = (state_q == SQ_ACCESS) && !hit_q && !cancel_q;
  assign rd_data    = beat_of(line_q, rd_last);
  assign cap_en     = (state_q == SQ_CAPTURE) && own_beat_valid && beat1_q;
  assign cap_line   = join_beats(lo_q, own_beat_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= SQ_IDLE;
      cnt_q    <= '0;
      hit_q    <= 1'b0;
      cancel_q <= 1'b0;
      beat1_q  <= 1'b0;
      addr_q   <= '0;
      line_q   <= '0;
      lo_q     <= '0;
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (accept) begin
          state_q  <= SQ_ACCESS;
          cnt_q    <= '0;
          addr_q   <= req_addr;
          hit_q    <= buf_hit;
          cancel_q <= 1'b0;
          if (buf_hit) line_q <= buf_line;
        end
        SQ_ACCESS: begin
          cnt_q <= cnt_q + 1'b1;
          if (snoop_now) cancel_q <= 1'b1;
          if (access_end) begin
            if (cancel_q || snoop_now) begin
              state_q <= SQ_CAPTURE;
              beat1_q <= 1'b0;
            end else begin
              if (!hit_q) line_q <= dram_rd_line;
              rd_valid <= 1'b1;
              rd_last  <= 1'b0;
              state_q  <= SQ_BEATS;
            end
          end
        end
        SQ_BEATS: begin
          if (!rd_last) begin
            rd_last <= 1'b1;
          end else begin
            rd_valid <= 1'b0;
            rd_last  <= 1'b0;
            state_q  <= SQ_IDLE;
          end
        end
        SQ_CAPTURE: if (own_beat_valid) begin
          if (!beat1_q) begin
            lo_q    <= own_beat_data;
            beat1_q <= 1'b1;
          end else begin
            beat1_q <= 1'b0;
            state_q <= SQ_IDLE;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mem_ctrl.sv
module mem_ctrl
  import mc_pkg::*;
#(
  parameter int LINE_AW    = 16,
  parameter int WB_DEPTH   = 4,
  parameter int ACCESS_CYC = 6,
  parameter int SNOOP_CYC  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_addr_valid,
  input  logic [LINE_AW-1:0] bus_addr,
  output logic               bus_addr_hold,
  input  logic               snoop_hitm,
  input  logic               own_beat_valid,
  input  logic [BEAT_W-1:0]  own_beat_data,
  output logic               rd_beat_valid,
  output logic [BEAT_W-1:0]  rd_beat_data,
  output logic               rd_beat_last,
  output logic               dram_rd_en,
  output logic [LINE_AW-1:0] dram_rd_addr,
  input  logic [LINE_W-1:0]  dram_rd_line,
  output logic               dram_wr_en,
  output logic [LINE_AW-1:0] dram_wr_addr,
  output logic [LINE_W-1:0]  dram_wr_line,
  input  logic               dram_wr_ready
);
  // named internal events, also used by the bound checker
  logic                busy;
  logic                wb_full;
  logic                ev_accept;
  logic                ev_capture;
  logic                ev_drain;
  logic                cancel_q;
  logic                look_hit;
  logic [LINE_W-1:0]   look_line;
  logic [LINE_W-1:0]   cap_line;
  logic [LINE_AW-1:0]  xact_addr;
  logic [WB_DEPTH-1:0] cap_match;
  logic                cap_match_any;
  logic                drain_pend;

  assign bus_addr_hold = busy || wb_full;
  assign ev_accept     = bus_addr_valid && !bus_addr_hold;
  assign ev_drain      = drain_pend && !busy && dram_wr_ready;
  assign dram_wr_en    = ev_drain;
  assign dram_rd_addr  = xact_addr;

  mc_seq #(
    .LINE_AW(LINE_AW), .ACCESS_CYC(ACCESS_CYC), .SNOOP_CYC(SNOOP_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n),
    .accept(ev_accept), .req_addr(bus_addr),
    .buf_hit(look_hit), .buf_line(look_line),
    .snoop_hitm(snoop_hitm),
    .own_beat_valid(own_beat_valid), .own_beat_data(own_beat_data),
    .dram_rd_line(dram_rd_line),
    .busy(busy), .dram_rd_en(dram_rd_en), .addr_q(xact_addr),
    .rd_valid(rd_beat_valid), .rd_last(rd_beat_last), .rd_data(rd_beat_data),
    .cap_en(ev_capture), .cap_line(cap_line), .cancel_q(cancel_q)
  );

  mc_wbuf #(
    .LINE_AW(LINE_AW), .WB_DEPTH(WB_DEPTH), .LINE_W(LINE_W)
  ) u_wbuf (
    .clk(clk), .rst_n(rst_n),
    .look_addr(bus_addr), .look_hit(look_hit), .look_line(look_line),
    .cap_en(ev_capture), .cap_addr(xact_addr), .cap_line(cap_line),
    .cap_match(cap_match), .cap_match_any(cap_match_any),
    .drain_pend(drain_pend), .drain_addr(dram_wr_addr), .drain_line(dram_wr_line),
    .drain_take(ev_drain), .full(wb_full)
  );
endmodule

// File: rtl/mc_props.sv
module mc_props #(
  parameter int WB_DEPTH   = 4,
  parameter int ACCESS_CYC = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                bus_addr_hold,
  input logic                rd_beat_valid,
  input logic                rd_beat_last,
  input logic                dram_rd_en,
  input logic                dram_wr_en,
  input logic                dram_wr_ready,
  input logic                ev_accept,
  input logic                ev_capture,
  input logic                cancel_q,
  input logic                wb_full,
  input logic                cap_match_any,
  input logic [WB_DEPTH-1:0] cap_match
);
  localparam int LW = $clog2(ACCESS_CYC + 4) + 1;
  logic [LW-1:0] lat_q;

  // cycles since the last accepted address phase, saturating
  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else if (ev_accept) lat_q <= LW'(1);
    else if (lat_q != '0 && lat_q != '1) lat_q <= lat_q + 1'b1;
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_beat_valid) |-> lat_q == LW'(ACCESS_CYC + 1));
  p_beat_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_beat_valid) |=> rd_beat_valid && rd_beat_last);
  p_cancel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_q |-> !rd_beat_valid);
  p_drain_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    dram_wr_en |-> dram_wr_ready && !dram_rd_en && !ev_capture);
  p_unique_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cap_match));
  p_slot_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_capture |-> cap_match_any || !wb_full);
  p_no_accept_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |-> !wb_full);
  p_single_xact_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_accept |=> bus_addr_hold);
endmodule

bind mem_ctrl mc_props #(.WB_DEPTH(WB_DEPTH), .ACCESS_CYC(ACCESS_CYC)) u_props (
  .clk(clk), .rst_n(rst_n), .bus_addr_hold(bus_addr_hold),
  .rd_beat_valid(rd_beat_valid), .rd_beat_last(rd_beat_last),
  .dram_rd_en(dram_rd_en), .dram_wr_en(dram_wr_en), .dram_wr_ready(dram_wr_ready),
  .ev_accept(ev_accept), .ev_capture(ev_capture), .cancel_q(cancel_q),
  .wb_full(wb_full), .cap_match_any(cap_match_any), .cap_match(cap_match)
);

// File: tb/sim_mem_ctrl.sv
`timescale 1ns/1ps
module sim_mem_ctrl;
  localparam int AW  = 8;
  localparam int DEP = 4;
  localparam int ACC = 6;
  localparam int SNP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic           bus_addr_valid = 1'b0;
  logic [AW-1:0]  bus_addr = '0;
  logic           bus_addr_hold;
  logic           snoop_hitm = 1'b0;
  logic           own_beat_valid = 1'b0;
  logic [127:0]   own_beat_data = '0;
  logic           rd_beat_valid, rd_beat_last;
  logic [127:0]   rd_beat_data;
  logic           dram_rd_en, dram_wr_en;
  logic [AW-1:0]  dram_rd_addr, dram_wr_addr;
  logic [255:0]   dram_rd_line, dram_wr_line;
  logic           dram_wr_ready = 1'b1;

  mem_ctrl #(.LINE_AW(AW), .WB_DEPTH(DEP), .ACCESS_CYC(ACC), .SNOOP_CYC(SNP)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr),
    .bus_addr_hold(bus_addr_hold), .snoop_hitm(snoop_hitm),
    .own_beat_valid(own_beat_valid), .own_beat_data(own_beat_data),
    .rd_beat_valid(rd_beat_valid), .rd_beat_data(rd_beat_data), .rd_beat_last(rd_beat_last),
    .dram_rd_en(dram_rd_en), .dram_rd_addr(dram_rd_addr), .dram_rd_line(dram_rd_line),
    .dram_wr_en(dram_wr_en), .dram_wr_addr(dram_wr_addr), .dram_wr_line(dram_wr_line),
    .dram_wr_ready(dram_wr_ready)
  );

  // behavioural DRAM
  logic [255:0] mem [1 << AW];
  int wr_count = 0;
  function automatic logic [255:0] init_line(input int a);
    return {32{8'(a)}} ^ {8{32'hA5C3_0F1E}};
  endfunction
  function automatic logic [255:0] own_line(input int s);
    return {4{64'h1357_9BDF_0246_8ACE ^ 64'(s * 32'h9E37_79B9)}};
  endfunction
  assign dram_rd_line = mem[dram_rd_addr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1 << AW); i++) mem[i] <= init_line(i);
    end else if (dram_wr_en && dram_wr_ready) begin
      mem[dram_wr_addr] <= dram_wr_line;
      wr_count <= wr_count + 1;
    end
  end

  int n_checks = 0;
  int n_fails  = 0;

  task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one bus read; hitm selects intervention by the owning cache
  task automatic xact(input int a, input bit hitm, input logic [255:0] line, input bit exp_dram_rd);
    bit early_data = 0, data_seen = 0, wr_in_win = 0, rd_seen = 0, hold_ok = 1;
    while (bus_addr_hold) @(negedge clk);
    bus_addr_valid = 1'b1;
    bus_addr = AW'(a);
    @(posedge clk);
    for (int k = 1; k <= ACC + 2; k++) begin
      @(negedge clk);
      bus_addr_valid = 1'b0;
      snoop_hitm = hitm && (k == SNP);
      if (dram_rd_en) rd_seen = 1;
      if (dram_wr_en) wr_in_win = 1;
      if (!bus_addr_hold) hold_ok = 0;
      if (k <= ACC && rd_beat_valid) early_data = 1;
      if (k > ACC) begin
        if (hitm) begin
          own_beat_valid = 1'b1;
          own_beat_data = (k == ACC + 1) ? line[127:0] : line[255:128];
          if (rd_beat_valid) data_seen = 1;
        end else begin
          chk(rd_beat_valid == 1'b1, "R1 beat valid", 256'(rd_beat_valid), 256'(1));
          chk(rd_beat_last == (k == ACC + 2), "R1 last flag", 256'(rd_beat_last), 256'(k == ACC + 2));
          chk(rd_beat_data == ((k == ACC + 1) ? line[127:0] : line[255:128]), "R1 beat data",
              256'(rd_beat_data), (k == ACC + 1) ? 256'(line[127:0]) : 256'(line[255:128]));
        end
      end
    end
    @(negedge clk);
    own_beat_valid = 1'b0;
    chk(!early_data, "R1 no beat before window", 256'(early_data), 256'(0));
    chk(hold_ok, "R9 hold during transaction", 256'(hold_ok), 256'(1));
    chk(!wr_in_win, "R4 no drain while busy", 256'(wr_in_win), 256'(0));
    if (hitm) chk(!data_seen, "R2 memory data cancelled", 256'(data_seen), 256'(0));
    else chk(rd_seen == exp_dram_rd, "R5 DRAM read use", 256'(rd_seen), 256'(exp_dram_rd));
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(!bus_addr_hold && !rd_beat_valid && !dram_rd_en && !dram_wr_en, "R8 reset state",
        256'({bus_addr_hold, rd_beat_valid, dram_rd_en, dram_wr_en}), 256'(0));
  endtask

  task automatic t_plain();
    dram_wr_ready = 1'b1;
    xact(3, 0, init_line(3), 1);
    xact(77, 0, init_line(77), 1);
    xact(255, 0, init_line(255), 1);
  endtask

  task automatic t_capture_and_fill();
    int w0;
    dram_wr_ready = 1'b0;
    w0 = wr_count;
    xact(10, 1, own_line(1), 0);
    xact(10, 0, own_line(1), 0);            // R5 served from buffer
    xact(50, 0, init_line(50), 1);          // R4 timing with writes blocked
    xact(10, 1, own_line(2), 0);            // R6 overwrite
    xact(20, 1, own_line(3), 0);
    xact(30, 1, own_line(4), 0);
    chk(bus_addr_hold == 1'b0, "R6 merge kept a slot free", 256'(bus_addr_hold), 256'(0));
    xact(40, 1, own_line(5), 0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(bus_addr_hold == 1'b1, "R7 hold while full", 256'(bus_addr_hold), 256'(1));
    end
    chk(wr_count == w0, "R4 no drain without ready", 256'(wr_count - w0), 256'(0));
  endtask

  task automatic t_drain();
    int w0;
    w0 = wr_count;
    dram_wr_ready = 1'b1;
    @(negedge clk);
    chk(bus_addr_hold == 1'b0, "R7 hold falls after drain", 256'(bus_addr_hold), 256'(0));
    repeat (6) @(negedge clk);
    chk(wr_count - w0 == 4, "R6 one write per buffered line", 256'(wr_count - w0), 256'(4));
    chk(mem[10] == own_line(2), "R3 R6 newest copy written", mem[10], own_line(2));
    chk(mem[20] == own_line(3), "R3 drained line", mem[20], own_line(3));
    chk(mem[40] == own_line(5), "R3 drained line", mem[40], own_line(5));
    xact(10, 0, own_line(2), 1);            // buffer empty, DRAM now current
    xact(60, 1, own_line(6), 0);
    @(negedge clk);
    chk(mem[60] == own_line(6), "R3 drain after idle", mem[60], own_line(6));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_capture_and_fill();
    t_drain();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule